// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block merges up to 32 interrupt sources into two processor interrupt lines, one fast and one normal. Each source is pending when its level-sensitive hardware input is high or its software-raised bit is set, and it counts only while its enable bit is set. A per-source route bit sends each enabled, pending source to the fast line or to the normal line. Enable bits and software bits each have a set address and a clear address. Writing a 1 to a bit changes that bit, and writing a 0 leaves it as it is. Software can therefore change one source without a read-modify-write sequence.

Sixteen vector slots give the handler address of the normal interrupt. Each slot names one source and holds a handler address. Slot 0 has the highest priority. The service routine reads a vector-address register. That read returns the address of the winning slot, or a default address when no slot qualifies, and it marks the winning slot as in service. While a slot is in service, only slots of strictly higher priority can win. A write of any value to the same register ends service of the most recent slot. A status register, a protection bit, a test-control bit and four identification bytes complete the register set.

The register port is a simple single-cycle bus. Writes take effect on the clock edge. Read data is combinational from the address.

Top module: `irqv_top`

## Requirements
- R1: A write to ENSET (0x010) sets every enable bit whose data bit is 1. A write to ENCLR (0x014) clears every enable bit whose data bit is 1. Data bits of 0 change nothing in either register. A read of 0x010 returns the enable bits.
- R2: A write to SWSET (0x018) sets software-raised bits wherever the data bit is 1. A write to SWCLR (0x01C) clears them wherever the data bit is 1. A read of 0x018 returns the software bits. A software bit makes its source pending just as a high hardware input does.
- R3: A source is active when it is pending and enabled. fast_irq_o is the OR of active sources whose route bit in ROUTE (0x00C, read/write) is 1. norm_irq_o is the OR of active sources whose route bit is 0.
- R4: A read of STAT (0x000) returns the active sources that are routed to the normal line, one bit per source.
- R5: Slot k has a handler address at 0x100+4k and a control word at 0x200+4k. In the control word, bits 4:0 hold the source index and bit 5 is the slot enable. A read of VADDR (0x030) returns the handler address of the lowest-numbered enabled slot whose source is active on the normal line.
- R6: When no slot qualifies, a VADDR read returns the default address held at DEFV (0x034, read/write). Disabled slots never qualify. Slots whose source is routed to the fast line never qualify.
- R7: A VADDR read that returns a slot address puts that slot in service. Until a write to VADDR ends that service, only slots with a lower number can win. Each VADDR write ends service of the most recently entered slot. Service can nest.
- R8: Reads at 0xFE0, 0xFE4, 0xFE8 and 0xFEC return bytes 0 to 3 of the identification word in bits 7:0, with the upper bits zero. The default word is 0x0026B3C1, which places vendor code 0x6B in bits 19:12.
- R9: PROT (0x020) and TEST (0x300) each hold one bit in bit 0. Each bit can be written and read back, and writing zero clears it.
- R10: After reset, every register, every slot and the service state are zero, and both outputs are low. Reads of unmapped addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| hw_irq | input | N_SRC | Level-sensitive source inputs |
| fast_irq_o | output | 1 | Fast interrupt request |
| norm_irq_o | output | 1 | Normal interrupt request |

## Verification
The bench nests service two levels deep. It checks that a second read while a slot is in service returns the default address, and not the same slot again. A design that compared priorities with "less or equal" would hand the serviced slot out twice. A design that never cleared in-service bits would lock out every slot after the first end-of-service write. The bench also raises sources on a disabled slot and on a fast-routed source. Either source must give the default address, so a design that ignores the slot enable or the route would return a slot address there. The set and clear writes carry data with zero bits over bits that are already set, so a design that stored the data word directly would lose those bits.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
   localparam int ADDR_W = 12;
   localparam int DATA_W = 32;

   localparam logic [ADDR_W-1:0] OFS_STAT  = 12'h000;
   localparam logic [ADDR_W-1:0] OFS_ROUTE = 12'h00C;
   localparam logic [ADDR_W-1:0] OFS_ENSET = 12'h010;
   localparam logic [ADDR_W-1:0] OFS_ENCLR = 12'h014;
   localparam logic [ADDR_W-1:0] OFS_SWSET = 12'h018;
   localparam logic [ADDR_W-1:0] OFS_SWCLR = 12'h01C;
   localparam logic [ADDR_W-1:0] OFS_PROT  = 12'h020;
   localparam logic [ADDR_W-1:0] OFS_VADDR = 12'h030;
   localparam logic [ADDR_W-1:0] OFS_DEFV  = 12'h034;
   localparam logic [ADDR_W-1:0] OFS_SLOTA = 12'h100;
   localparam logic [ADDR_W-1:0] OFS_SLOTC = 12'h200;
   localparam logic [ADDR_W-1:0] OFS_TEST  = 12'h300;
   localparam logic [ADDR_W-1:0] OFS_ID    = 12'hFE0;

   typedef struct packed {
      logic              rd;
      logic              wr;
      logic [ADDR_W-1:0] addr;
      logic [DATA_W-1:0] wdata;
   } bus_req_t;
endpackage

// File: rtl/irqv_srcregs.sv
module irqv_srcregs
   import irqv_pkg::*;
#(
   parameter int N_SRC = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bus_req_t          req,
   input  logic [N_SRC-1:0]  hw_irq,
   output logic [N_SRC-1:0]  en_q,
   output logic [N_SRC-1:0]  soft_q,
   output logic [N_SRC-1:0]  route_q,
   output logic [N_SRC-1:0]  norm_act,
   output logic [N_SRC-1:0]  fast_act,
   output logic [DATA_W-1:0] rd_data
);
   logic [N_SRC-1:0] wbits;
   logic [N_SRC-1:0] pend;
   logic             prot_q;
   logic             test_q;

   assign wbits = req.wdata[N_SRC-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= '0;
         soft_q  <= '0;
         route_q <= '0;
         prot_q  <= 1'b0;
         test_q  <= 1'b0;
      end else if (req.wr) begin
         case (req.addr)
            OFS_ENSET: en_q    <= en_q | wbits;
            OFS_ENCLR: en_q    <= en_q & ~wbits;
            OFS_SWSET: soft_q  <= soft_q | wbits;
            OFS_SWCLR: soft_q  <= soft_q & ~wbits;
            OFS_ROUTE: route_q <= wbits;
            OFS_PROT:  prot_q  <= req.wdata[0];
            OFS_TEST:  test_q  <= req.wdata[0];
            default: ;
         endcase
      end
   end

   assign pend     = (hw_irq | soft_q) & en_q;
   assign norm_act = pend & ~route_q;
   assign fast_act = pend & route_q;

   always_comb begin
      rd_data = '0;
      if (req.rd) begin
         case (req.addr)
            OFS_STAT:  rd_data[N_SRC-1:0] = norm_act;
            OFS_ROUTE: rd_data[N_SRC-1:0] = route_q;
            OFS_ENSET: rd_data[N_SRC-1:0] = en_q;
            OFS_SWSET: rd_data[N_SRC-1:0] = soft_q;
            OFS_PROT:  rd_data[0]         = prot_q;
            OFS_TEST:  rd_data[0]         = test_q;
            default:   rd_data            = '0;
         endcase
      end
   end
endmodule

// File: rtl/irqv_slots.sv
module irqv_slots
   import irqv_pkg::*;
#(
   parameter int N_SRC   = 32,
   parameter int N_SLOT  = 16,
   parameter bit NEST_EN = 1'b1,
   localparam int IDX_W  = $clog2(N_SRC),
   localparam int SL_W   = (N_SLOT > 1) ? $clog2(N_SLOT) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bus_req_t          req,
   input  logic [N_SRC-1:0]  norm_act,
   output logic [DATA_W-1:0] rd_data,
   output logic [N_SLOT-1:0] in_service,
   output logic              win_valid,
   output logic [SL_W-1:0]   win_idx
);
   logic [DATA_W-1:0] vaddr_q [N_SLOT];
   logic              ven_q   [N_SLOT];
   logic [IDX_W-1:0]  vsrc_q  [N_SLOT];
   logic [DATA_W-1:0] def_q;
   logic [N_SLOT-1:0] slot_hit;
   logic [N_SLOT-1:0] allow;
   logic [DATA_W-1:0] vec_now;
   logic              vec_rd;
   logic              vec_wr;

   assign vec_rd = req.rd && (req.addr == OFS_VADDR);
   assign vec_wr = req.wr && (req.addr == OFS_VADDR);

   for (genvar k = 0; k < N_SLOT; k++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vaddr_q[k] <= '0;
            ven_q[k]   <= 1'b0;
            vsrc_q[k]  <= '0;
         end else if (req.wr) begin
            if (req.addr == OFS_SLOTA + ADDR_W'(4*k))
               vaddr_q[k] <= req.wdata;
            if (req.addr == OFS_SLOTC + ADDR_W'(4*k)) begin
               ven_q[k]  <= req.wdata[IDX_W];
               vsrc_q[k] <= req.wdata[IDX_W-1:0];
            end
         end
      end
      assign slot_hit[k] = ven_q[k] & norm_act[vsrc_q[k]];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         def_q <= '0;
      else if (req.wr && req.addr == OFS_DEFV)
         def_q <= req.wdata;
   end

   if (NEST_EN) begin : g_nest
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            in_service <= '0;
         else if (vec_rd && win_valid)
            in_service[win_idx] <= 1'b1;
         else if (vec_wr)
            in_service <= in_service & (in_service - N_SLOT'(1));
      end
      always_comb begin
         logic blocked;
         blocked = 1'b0;
         for (int k = 0; k < N_SLOT; k++) begin
            blocked  = blocked | in_service[k];
            allow[k] = ~blocked;
         end
      end
   end else begin : g_flat
      assign in_service = '0;
      assign allow      = '1;
   end

   always_comb begin
      win_valid = 1'b0;
      win_idx   = '0;
      for (int k = N_SLOT - 1; k >= 0; k--) begin
         if (slot_hit[k] && allow[k]) begin
            win_valid = 1'b1;
            win_idx   = SL_W'(k);
         end
      end
   end

   assign vec_now = win_valid ? vaddr_q[win_idx] : def_q;

   always_comb begin
      rd_data = '0;
      if (req.rd) begin
         if (req.addr == OFS_VADDR) rd_data = vec_now;
         if (req.addr == OFS_DEFV)  rd_data = def_q;
         for (int k = 0; k < N_SLOT; k++) begin
            if (req.addr == OFS_SLOTA + ADDR_W'(4*k))
               rd_data = vaddr_q[k];
            if (req.addr == OFS_SLOTC + ADDR_W'(4*k)) begin
               rd_data[IDX_W]       = ven_q[k];
               rd_data[IDX_W-1:0]   = vsrc_q[k];
            end
         end
      end
   end
endmodule

// File: rtl/irqv_top.sv
module irqv_top
   import irqv_pkg::*;
#(
   parameter int          N_SRC    = 32,
   parameter int          N_SLOT   = 16,
   parameter bit          NEST_EN  = 1'b1,
   parameter logic [11:0] PART_NUM = 12'h3C1,
   parameter logic [7:0]  VENDOR   = 8'h6B,
   parameter logic [3:0]  REVISION = 4'h2,
   parameter logic [7:0]  CFG_BYTE = 8'h00,
   localparam int         SL_W     = (N_SLOT > 1) ? $clog2(N_SLOT) : 1,
   localparam logic [31:0] ID_WORD = {CFG_BYTE, REVISION, VENDOR, PART_NUM}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [11:0]       bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [N_SRC-1:0]  hw_irq,
   output logic              fast_irq_o,
   output logic              norm_irq_o
);
   if (N_SRC < 2 || N_SRC > DATA_W) begin : g_bad_src
      $error("irqv_top: N_SRC must lie in 2..32");
   end
   if (N_SLOT < 1 || N_SLOT > 64) begin : g_bad_slot
      $error("irqv_top: N_SLOT must lie in 1..64");
   end

   bus_req_t          req;
   logic [N_SRC-1:0]  en_q, soft_q, route_q, norm_act, fast_act;
   logic [DATA_W-1:0] rd_src, rd_slot, rd_id;
   logic [N_SLOT-1:0] in_service;
   logic              win_valid;
   logic [SL_W-1:0]   win_idx;

   assign req.rd    = bus_sel & ~bus_wr;
   assign req.wr    = bus_sel & bus_wr;
   assign req.addr  = bus_addr;
   assign req.wdata = bus_wdata;

   irqv_srcregs #(.N_SRC(N_SRC)) u_src (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (req),
      .hw_irq   (hw_irq),
      .en_q     (en_q),
      .soft_q   (soft_q),
      .route_q  (route_q),
      .norm_act (norm_act),
      .fast_act (fast_act),
      .rd_data  (rd_src)
   );

   irqv_slots #(.N_SRC(N_SRC), .N_SLOT(N_SLOT), .NEST_EN(NEST_EN)) u_slots (
      .clk        (clk),
      .rst_n      (rst_n),
      .req        (req),
      .norm_act   (norm_act),
      .rd_data    (rd_slot),
      .in_service (in_service),
      .win_valid  (win_valid),
      .win_idx    (win_idx)
   );

   logic [7:0] id_sel [4];
   for (genvar b = 0; b < 4; b++) begin : g_id
      assign id_sel[b] = (req.rd && bus_addr == OFS_ID + ADDR_W'(4*b))
                         ? ID_WORD[8*b +: 8] : 8'h00;
   end
   assign rd_id = {24'h0, id_sel[0] | id_sel[1] | id_sel[2] | id_sel[3]};

   assign bus_rdata  = rd_src | rd_slot | rd_id;
   assign fast_irq_o = |fast_act;
   assign norm_irq_o = |norm_act;
endmodule

// File: rtl/irqv_chk.sv
module irqv_chk
   import irqv_pkg::*;
#(
   parameter int N_SRC  = 32,
   parameter int N_SLOT = 16,
   localparam int SL_W  = (N_SLOT > 1) ? $clog2(N_SLOT) : 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [11:0]       bus_addr,
   input logic [31:0]       bus_wdata,
   input logic [31:0]       bus_rdata,
   input logic              norm_irq_o,
   input logic [N_SRC-1:0]  en_q,
   input logic [N_SRC-1:0]  soft_q,
   input logic [N_SLOT-1:0] in_service,
   input logic              win_valid,
   input logic [SL_W-1:0]   win_idx
);
   logic wr_now, rd_now;
   assign wr_now = bus_sel & bus_wr;
   assign rd_now = bus_sel & ~bus_wr;

   p_enset_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_now && bus_addr == OFS_ENSET) |=>
      ((en_q & $past(bus_wdata[N_SRC-1:0])) == $past(bus_wdata[N_SRC-1:0])));

   p_enclr_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_now && bus_addr == OFS_ENCLR) |=>
      ((en_q & $past(bus_wdata[N_SRC-1:0])) == '0));

   p_swclr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_now && bus_addr == OFS_SWCLR) |=>
      ((soft_q & $past(bus_wdata[N_SRC-1:0])) == '0));

   p_norm_needs_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
      norm_irq_o |-> (en_q != '0));

   p_status_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_now && bus_addr == OFS_STAT) |-> ((bus_rdata[N_SRC-1:0] & ~en_q) == '0));

   p_no_push_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_now && bus_addr == OFS_VADDR && !win_valid) |=> $stable(in_service));

   p_push_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_now && bus_addr == OFS_VADDR && win_valid) |=>
      ($countones(in_service) == $countones($past(in_service)) + 1));

   p_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_now && bus_addr == OFS_VADDR && in_service != '0) |=>
      ($countones(in_service) + 1 == $countones($past(in_service))));

   p_win_above_r7: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid |-> ((in_service & ((N_SLOT'(1) << win_idx) << 1) - N_SLOT'(1)) == '0)
                    || (in_service[win_idx] == 1'b0 &&
                        ((in_service & ((N_SLOT'(2) << win_idx) - N_SLOT'(1))) == '0)));

   p_id_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_now && bus_addr[11:4] == 8'hFE && bus_addr[1:0] == 2'b00) |->
      (bus_rdata[31:8] == 24'h0));
endmodule

bind irqv_top irqv_chk #(.N_SRC(N_SRC), .N_SLOT(N_SLOT)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_sel    (bus_sel),
   .bus_wr     (bus_wr),
   .bus_addr   (bus_addr),
   .bus_wdata  (bus_wdata),
   .bus_rdata  (bus_rdata),
   .norm_irq_o (norm_irq_o),
   .en_q       (en_q),
   .soft_q     (soft_q),
   .in_service (in_service),
   .win_valid  (win_valid),
   .win_idx    (win_idx)
);

// File: tb/irqv_top_test.sv
module irqv_top_test;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        bus_sel, bus_wr;
   logic [11:0] bus_addr;
   logic [31:0] bus_wdata, bus_rdata;
   logic [31:0] hw_irq;
   logic        fast_irq_o, norm_irq_o;

   always #5 clk = ~clk;

   irqv_top uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .hw_irq(hw_irq), .fast_irq_o(fast_irq_o), .norm_irq_o(norm_irq_o)
   );

   int n_cmp = 0, n_bad = 0;
   bit done = 0;

   // behavioural reference
   logic [31:0] m_en = 0, m_soft = 0, m_sel = 0, m_hw = 0, m_def = 0;
   logic        m_prot = 0, m_test = 0;
   logic [31:0] m_va [16];
   logic [5:0]  m_vc [16];
   int          stk [$];

   function automatic logic [31:0] m_norm();
      return ((m_hw | m_soft) & m_en) & ~m_sel;
   endfunction
   function automatic logic [31:0] m_fast();
      return ((m_hw | m_soft) & m_en) & m_sel;
   endfunction
   function automatic int m_win();
      int lim;
      logic [31:0] nm;
      nm  = m_norm();
      lim = (stk.size() > 0) ? stk[0] : 16;
      for (int k = 0; k < lim; k++)
         if (m_vc[k][5] && nm[m_vc[k][4:0]]) return k;
      return -1;
   endfunction
   function automatic logic [31:0] m_read(logic [11:0] a);
      int w;
      logic [31:0] id;
      id = 32'h0026B3C1;
      if (a >= 12'h100 && a < 12'h140 && a[1:0] == 0) return m_va[(a - 12'h100) >> 2];
      if (a >= 12'h200 && a < 12'h240 && a[1:0] == 0) return {26'h0, m_vc[(a - 12'h200) >> 2]};
      case (a)
         12'h000: return m_norm();
         12'h00C: return m_sel;
         12'h010: return m_en;
         12'h018: return m_soft;
         12'h020: return {31'h0, m_prot};
         12'h300: return {31'h0, m_test};
         12'h034: return m_def;
         12'h030: begin w = m_win(); return (w >= 0) ? m_va[w] : m_def; end
         12'hFE0: return {24'h0, id[7:0]};
         12'hFE4: return {24'h0, id[15:8]};
         12'hFE8: return {24'h0, id[23:16]};
         12'hFEC: return {24'h0, id[31:24]};
         default: return 32'h0;
      endcase
   endfunction
   function automatic void m_write(logic [11:0] a, logic [31:0] d);
      if (a >= 12'h100 && a < 12'h140 && a[1:0] == 0) m_va[(a - 12'h100) >> 2] = d;
      else if (a >= 12'h200 && a < 12'h240 && a[1:0] == 0) m_vc[(a - 12'h200) >> 2] = d[5:0];
      else case (a)
         12'h010: m_en   = m_en | d;
         12'h014: m_en   = m_en & ~d;
         12'h018: m_soft = m_soft | d;
         12'h01C: m_soft = m_soft & ~d;
         12'h00C: m_sel  = d;
         12'h020: m_prot = d[0];
         12'h300: m_test = d[0];
         12'h034: m_def  = d;
         12'h030: if (stk.size() > 0) void'(stk.pop_front());
         default: ;
      endcase
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic outs();
      check("R3 fast_irq_o", {31'h0, fast_irq_o}, {31'h0, |m_fast()});
      check("R3 norm_irq_o", {31'h0, norm_irq_o}, {31'h0, |m_norm()});
   endtask

   task automatic wr(logic [11:0] a, logic [31:0] d);
      bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      m_write(a, d);
      #2 bus_sel = 0; bus_wr = 0;
      outs();
   endtask

   task automatic rd(logic [11:0] a, string tag);
      int w;
      bus_sel = 1; bus_wr = 0; bus_addr = a;
      #1 check(tag, bus_rdata, m_read(a));
      w = m_win();
      @(posedge clk);
      if (a == 12'h030 && w >= 0) stk.push_front(w);
      #2 bus_sel = 0;
      outs();
   endtask

   task automatic set_hw(logic [31:0] v);
      hw_irq = v; m_hw = v;
      @(posedge clk); #2 outs();
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #2000000;
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      for (int k = 0; k < 16; k++) begin m_va[k] = 0; m_vc[k] = 0; end
      rst_n = 0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0; hw_irq = 0;
      repeat (3) @(posedge clk);
      #2 rst_n = 1;
      // R10 reset state
      outs();
      rd(12'h000, "R10 stat");
      rd(12'h010, "R10 enable");
      rd(12'h018, "R10 soft");
      rd(12'h030, "R10 vaddr");
      rd(12'h204, "R10 slot ctl");
      rd(12'h0A8, "R10 unmapped");
      // R1 enable set/clear
      wr(12'h010, 32'h0000_00F0); rd(12'h010, "R1 enset");
      wr(12'h010, 32'h0000_000F); rd(12'h010, "R1 zeros keep");
      wr(12'h014, 32'h0000_0030); rd(12'h010, "R1 enclr");
      // R2 software raise
      wr(12'h018, 32'h0000_0005); rd(12'h018, "R2 swset");
      rd(12'h000, "R4 stat soft");
      wr(12'h01C, 32'h0000_0001); rd(12'h018, "R2 swclr");
      wr(12'h01C, 32'h0000_0004);
      // R3 routing
      wr(12'h00C, 32'h0000_0080); rd(12'h00C, "R3 route rb");
      set_hw(32'h0000_0080);
      rd(12'h000, "R4 stat fast excl");
      wr(12'h00C, 32'h0);
      set_hw(32'h0000_0180);
      rd(12'h000, "R4 stat masked");
      set_hw(32'h0);
      // R5..R7 vectors
      wr(12'h034, 32'hDEAD_0000);
      wr(12'h100, 32'h0000_1000); wr(12'h200, {26'h0, 1'b1, 5'd2});
      wr(12'h10C, 32'h0000_1300); wr(12'h20C, {26'h0, 1'b1, 5'd7});
      wr(12'h114, 32'h0000_1500); wr(12'h214, {26'h0, 1'b0, 5'd4});
      rd(12'h20C, "R5 ctl rb");
      wr(12'h010, 32'h0000_0010);
      rd(12'h030, "R6 none active");
      set_hw(32'h0000_0010);
      rd(12'h030, "R6 disabled slot");
      set_hw(32'h0000_0080);
      rd(12'h030, "R5 slot3");
      rd(12'h030, "R7 same level blocked");
      wr(12'h018, 32'h0000_0004);
      rd(12'h030, "R7 nest slot0");
      rd(12'h030, "R7 top blocked");
      wr(12'h030, 32'h0);
      rd(12'h030, "R7 after one eoi");
      wr(12'h030, 32'h0); wr(12'h030, 32'h0);
      wr(12'h01C, 32'h0000_0004);
      rd(12'h030, "R5 back to slot3");
      wr(12'h030, 32'h0);
      wr(12'h00C, 32'h0000_0080);
      rd(12'h030, "R6 fast routed");
      wr(12'h00C, 32'h0);
      set_hw(32'h0);
      // R8 identification
      rd(12'hFE0, "R8 id0"); rd(12'hFE4, "R8 id1");
      rd(12'hFE8, "R8 id2"); rd(12'hFEC, "R8 id3");
      // R9 protection and test bits
      wr(12'h020, 32'hFFFF_FFFF); rd(12'h020, "R9 prot set");
      wr(12'h300, 32'h1);         rd(12'h300, "R9 test set");
      wr(12'h020, 32'h0);         rd(12'h020, "R9 prot clr");
      wr(12'h300, 32'h0);         rd(12'h300, "R9 test clr");
      repeat (4) begin @(posedge clk); #2 outs(); end
      summary();
   end
endmodule